// File: doc/BRIEF.md
# Lock-On Watchdog Reset Timer

This block is a countdown watchdog. A processor reaches it through a small 16-bit register port. After reset the timer sits idle and asks for nothing. Software arms it by writing a 1 to the arm bit. From then on the counter runs down from a timeout value that is fixed when the block is built. Software cannot stop it, and software cannot change that timeout.

To keep the system alive, software writes to the kick register at regular intervals. Each such write puts the count back to the full timeout. If the count runs out with no kick, the block raises a reset request for exactly one clock. The request goes to the system reset logic, which is outside this block. The counter then reloads and keeps running. Only an external reset of the block returns it to the idle state.

Top module: `lockon_watchdog`

## Requirements
- R1: After reset the status run bit (status offset 0, bit 0) reads 0 and `wd_reset_req` stays low. It stays low for as long as the timer is not armed, however long that is.
- R2: A write to the control register (offset 1) with bit 0 set arms the timer. From the next read onward, status bit 0 reads 1.
- R3: Once armed, no later write to the control register stops the timer or reloads its count. This covers writes with the halt bit (bit 1) set, writes of zero, and repeated arm writes.
- R4: When the timer is armed and nothing else intervenes, `wd_reset_req` goes high for exactly one cycle. That cycle is the one following clock edge number `TIMEOUT_CYCLES` after the arming edge.
- R5: A write of any data to the kick register (offset 2) reloads the count. The next request then comes `TIMEOUT_CYCLES` edges after that write's edge.
- R6: A kick whose edge coincides with the edge on which the request would be raised suppresses that request and reloads the count.
- R7: After a request, the count reloads by itself. With no kick, another request follows `TIMEOUT_CYCLES` edges later.
- R8: A kick written while the timer is idle does not arm it.
- R9: Read data appears on `bus_rdata` one edge after `bus_rd`. Offsets other than status (control, kick and the unused offset 3) read as zero.
- R10: Asserting `rst_n` while the timer is armed returns it to idle: the run bit is 0 and no further request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; returns the block to idle |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset: 0 status, 1 control, 2 kick |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wd_reset_req | output | 1 | One-cycle reset request raised on expiry |

## Verification
The hardest case to reach from the ports is a kick that lands on exactly the edge where the request would be raised (R6). One edge earlier or later tests something else. The bench counts edges from its own arm and kick writes. It then schedules the kick with a task that waits for the precise edge before it drives the strobe. The bench also lets two back-to-back expiries run with no kick (R7), so that the automatic reload is timed against the scoreboard's queue of expected request cycles.

// File: rtl/lockon_wd_pkg.sv
package lockon_wd_pkg;
  localparam int ADDR_W_P = 2;
  localparam int DATA_W_P = 16;

  typedef enum logic [ADDR_W_P-1:0] {
    OFS_STATUS = 2'd0,
    OFS_CTRL   = 2'd1,
    OFS_KICK   = 2'd2,
    OFS_SPARE  = 2'd3
  } wd_ofs_e;

  localparam int CTRL_ARM_BIT  = 0;
  localparam int CTRL_HALT_BIT = 1;
  localparam int STAT_RUN_BIT  = 0;
endpackage

// File: rtl/lockon_wd_regs.sv
module lockon_wd_regs
  import lockon_wd_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_P,
  parameter int DATA_W = DATA_W_P
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              armed_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_ctrl, hit_kick, hit_stat;

  always_comb begin
    hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
    hit_kick = (addr_i == ADDR_W'(OFS_KICK));
    hit_stat = (addr_i == ADDR_W'(OFS_STATUS));
  end

  // A kick is any write to the kick offset, whatever the data.
  assign kick_o = wr_i && hit_kick;

  // Arm flag: set-only. The halt bit is decoded nowhere.
  always_ff @(posedge clk) begin
    if (!rst_n)
      armed_o <= 1'b0;
    else if (wr_i && hit_ctrl && wdata_i[CTRL_ARM_BIT])
      armed_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_o <= '0;
    else if (rd_i) begin
      rdata_o <= '0;
      if (hit_stat)
        rdata_o[STAT_RUN_BIT] <= armed_o;
    end
  end

  // R3
  stay_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> armed_o);

  // R9
  rdata_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !hit_stat) |=> (rdata_o == '0));
endmodule

// File: rtl/lockon_wd_count.sv
module lockon_wd_count #(
  parameter int TIMEOUT_CYCLES = 1000000,
  localparam int CW = $clog2(TIMEOUT_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic kick_i,
  output logic zero_o
);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= LOAD;
    else if (kick_i || !armed_i)
      cnt_q <= LOAD;
    else if (cnt_q == '0)
      cnt_q <= LOAD;
    else
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = armed_i && (cnt_q == '0);

  // R5
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == LOAD));

  // R7
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !kick_i) |=> (cnt_q == LOAD));
endmodule

// File: rtl/lockon_wd_req.sv
module lockon_wd_req (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_i,
  input  logic kick_i,
  output logic req_o
);
  // A kick on the expiry edge wins over the request.
  always_ff @(posedge clk) begin
    if (!rst_n)
      req_o <= 1'b0;
    else
      req_o <= zero_i && !kick_i;
  end

  // R4
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R6
  kick_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !req_o);
endmodule

// File: rtl/lockon_watchdog.sv
module lockon_watchdog
  import lockon_wd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int ADDR_W = ADDR_W_P,
  parameter int DATA_W = DATA_W_P
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_reset_req
);
  logic armed, kick, zero;

  initial begin
    timeout_min_chk: assert (TIMEOUT_CYCLES >= 2);
  end

  lockon_wd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata),
    .armed_o(armed), .kick_o(kick), .rdata_o(bus_rdata)
  );

  lockon_wd_count #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) count_i (
    .clk(clk), .rst_n(rst_n), .armed_i(armed), .kick_i(kick),
    .zero_o(zero)
  );

  lockon_wd_req req_i (
    .clk(clk), .rst_n(rst_n), .zero_i(zero), .kick_i(kick),
    .req_o(wd_reset_req)
  );

  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !wd_reset_req);
endmodule

// File: tb/lockon_watchdog_tb.sv
module lockon_watchdog_tb_top;
  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic wd_reset_req;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lockon_watchdog #(.TIMEOUT_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wd_reset_req(wd_reset_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops the expected request cycles and compares them.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wd_reset_req) begin
        if (exp_q.size() == 0) chk(1'b0, "R1/R6 unexpected request", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R4/R5/R7 request cycle", cyc, e);
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        int e;
        e = exp_q.pop_front();
        chk(1'b0, "R4/R5/R7 missing request", 0, e);
      end
    end
  end

  // Driver: a write on the next edge; returns the index of that edge.
  task automatic wr(input logic [1:0] a, input logic [15:0] d, output int edge_n);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    edge_n = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic kick_at(input int target);
    @(negedge clk);
    while (cyc != target - 1) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0000;
    @(posedge clk); #1;
    chk(cyc == target, "R6 kick edge placement", cyc, target);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    chk(1'b0, "watchdog timeout", cyc, 5000);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [15:0] d;
    int n, k, j, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk(wd_reset_req == 1'b0, "R1 request low after reset", wd_reset_req, 0);
    rd(2'd0, d);
    chk(d == 16'h0, "R1 run bit after reset", d, 0);
    // R8: a kick while idle does not arm
    wr(2'd2, 16'h0001, e);
    repeat (3 * T) @(negedge clk);
    rd(2'd0, d);
    chk(d == 16'h0, "R8 idle after kick", d, 0);
    // R2: arm
    wr(2'd1, 16'h0001, n);
    exp_q.push_back(n + T);
    rd(2'd0, d);
    chk(d == 16'h1, "R2 run bit after arm", d, 1);
    // R3: halt, zero and repeat arm writes change nothing
    wr(2'd1, 16'h0002, e);
    wr(2'd1, 16'h0000, e);
    wr(2'd1, 16'h0001, e);
    rd(2'd0, d);
    chk(d == 16'h1, "R3 still armed after halt write", d, 1);
    // R4 checked by the monitor at n+T
    wait_until(n + T + 3);
    chk(exp_q.size() == 0, "R4 first request consumed", exp_q.size(), 0);
    // R5: kick reloads; R7: a second expiry follows without a kick
    wr(2'd2, 16'hBEEF, k);
    exp_q.push_back(k + T);
    exp_q.push_back(k + 2 * T);
    wait_until(k + 2 * T + 2);
    chk(exp_q.size() == 0, "R7 both requests consumed", exp_q.size(), 0);
    // R6: a kick on the expiry edge suppresses that request
    j = k + 3 * T;
    kick_at(j);
    exp_q.push_back(j + T);
    wait_until(j + T + 2);
    chk(exp_q.size() == 0, "R6 next request after suppressed one", exp_q.size(), 0);
    // R9: non-status offsets read zero
    rd(2'd1, d);
    chk(d == 16'h0, "R9 control reads zero", d, 0);
    rd(2'd2, d);
    chk(d == 16'h0, "R9 kick reads zero", d, 0);
    rd(2'd3, d);
    chk(d == 16'h0, "R9 spare reads zero", d, 0);
    rd(2'd0, d);
    chk(d == 16'h1, "R9 status reads run", d, 1);
    // R10: reset while running returns to idle
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3 * T) @(negedge clk);
    rd(2'd0, d);
    chk(d == 16'h0, "R10 idle after reset", d, 0);
    chk(wd_reset_req == 1'b0, "R10 no request after reset", wd_reset_req, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule